// File: doc/BRIEF.md
# Ratio-Locked Clock-Crossing Queue

This block carries a handshaked 32-bit word stream from a source domain to a destination domain. Both domain clocks are integer divisions of one master clock, for example master/2 for the fast domain, master/3 for the middle domain and master/9 for the slow one. Because every domain clock comes from the same master clock, their phase relationship repeats and is known in advance. The block therefore needs no synchronizer chains. It runs on the master clock and rebuilds each domain's rising edges as one-cycle strobes from a divisor given on a configuration input. The source side and the destination side act only on their own strobes.

A domain edge that lands one master cycle next to an edge of the other domain counts as phase-misaligned, and a handshake on it is normally withheld. Edges that coincide with the other domain's edge, or that have at least one clear master cycle on both sides, are safe. The block stores two entries. It also records, for each entry, whether the entry was already present at an earlier edge of the consuming domain, and for each free slot, whether the slot was already free at an earlier edge of the producing domain. A recorded entry or slot may be handshaked even on a misaligned edge, so a word that has waited a full local period does not stall needlessly.

Used between processing elements that run at different voltage and frequency levels, one instance serves each ordered pair of domains. Set both divisors to 1 and the block is an ordinary two-entry synchronous queue.

Top module: `ratio_xing_queue`

## Requirements
- R1: In the first master cycle after reset release the queue is empty (`dstValid` low), and a write is accepted on that cycle's source edge (`srcReady` high), because both slots count as long free.
- R2: Counting master cycles from 0 at reset release, a source edge occurs in cycle n when n mod `srcDiv` is 0, and a destination edge when n mod `dstDiv` is 0. Outside its own edges, `srcReady` and `dstValid` are low.
- R3: An edge is safe when the other domain has an edge in the same master cycle, or when the other domain has no edge in the master cycle just before it and none in the master cycle just after it. Cycle 0 has no predecessor.
- R4: On a destination edge, `dstValid` is high exactly when the queue holds a word and either the edge is safe or the head word was written in a master cycle before the previous destination edge.
- R5: On a source edge, `srcReady` is high exactly when a slot is free and either the edge is safe, or the slot being written has never held data, or the word that last occupied it was read in a master cycle before the previous source edge.
- R6: The queue holds at most two words. With two words held, `srcReady` stays low.
- R7: Words appear on `dstData` in write order, with none lost and none duplicated, for every ordered pair of divisors 2, 3 and 9 under random source gaps and destination backpressure. A transfer takes place on a cycle where valid and ready are both high.
- R8: With both divisors set to 1, every master cycle is a safe edge on both sides and the block acts as a plain two-entry synchronous queue.
- R9: Divisors from 1 to 15 are accepted and must be held stable while reset is inactive. A value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock from which both domain clocks are divided |
| rstN | input | 1 | Active-low synchronous reset |
| srcDiv | input | 4 | Source domain divisor relative to the master clock |
| dstDiv | input | 4 | Destination domain divisor relative to the master clock |
| srcValid | input | 1 | Source offers a word |
| srcReady | output | 1 | Word accepted on this source edge |
| srcData | input | 32 | Source word |
| dstValid | output | 1 | Head word offered on this destination edge |
| dstReady | input | 1 | Destination takes the word |
| dstData | output | 32 | Head word |

## Verification
The stream runs under every ordered pairing of the fast, middle and slow divisors. The pairs of equal divisors, where all edges coincide, are kept apart from the unequal pairs, where only some edges line up and the others depend on the residency flags. A bench model predicts `srcReady` and `dstValid` on every master cycle from its own edge arithmetic and the write and read times it has recorded. This shows whether the block withholds a misaligned edge too often, which costs throughput, or too rarely, which breaks the crossing rule. A directed stall with the destination blocked fills both slots to check the capacity limit. A drain at the end of each pairing, together with a sequence-numbered payload, exposes any lost, repeated or reordered word. A run with both divisors set to 1 confirms the plain-queue behaviour.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // strobes issued by the control to the storage
  typedef struct packed {
    logic wrEn;     // accept srcData into the tail slot
    logic rdEn;     // retire the head slot
    logic srcEdge;  // source domain rising edge this master cycle
    logic dstEdge;  // destination domain rising edge this master cycle
  } xferStrobes_t;

  // slot state reported by the storage back to the control
  typedef struct packed {
    logic tailFree;   // tail slot is empty
    logic tailAged;   // tail slot was already empty at an earlier source edge
    logic headFull;   // head slot holds a word
    logic headAged;   // head word was already present at an earlier destination edge
  } storeStatus_t;

endpackage

// File: rtl/rxq_edge_gen.sv
module rxq_edge_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             tickNext,
  output logic             tickPrev
);

  logic [DIV_W-1:0] phaseCnt;
  logic [DIV_W-1:0] lastIdx;

  // a divisor of zero behaves as one
  assign lastIdx  = (div == '0) ? '0 : div - DIV_W'(1);
  assign tick     = (phaseCnt == '0);
  assign tickNext = (phaseCnt >= lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      tickPrev <= 1'b0;
    end else begin
      phaseCnt <= (phaseCnt >= lastIdx) ? '0 : phaseCnt + DIV_W'(1);
      tickPrev <= tick;
    end
  end

  // two edges of a divided clock are never adjacent when the divisor exceeds one
  p_edge_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && div > DIV_W'(1)) |=> !tick);

  // the edge preview always agrees with the following cycle
  p_edge_preview_r2: assert property (@(posedge clk) disable iff (!rstN)
    tickNext |=> tick);

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] srcDiv,
  input  logic [DIV_W-1:0] dstDiv,
  input  logic             srcTick,
  input  logic             srcNext,
  input  logic             srcPrev,
  input  logic             dstTick,
  input  logic             dstNext,
  input  logic             dstPrev,
  input  logic             srcValid,
  input  logic             dstReady,
  input  storeStatus_t     status,
  output logic             srcReady,
  output logic             dstValid,
  output xferStrobes_t     strobes
);

  logic srcSafe;
  logic dstSafe;
  logic srcNearDst;
  logic dstNearSrc;

  // an other-domain edge one master cycle away marks a misaligned edge
  assign srcNearDst = dstPrev | dstNext;
  assign dstNearSrc = srcPrev | srcNext;

  assign srcSafe = srcTick & (dstTick | ~srcNearDst);
  assign dstSafe = dstTick & (srcTick | ~dstNearSrc);

  // misaligned edges proceed only when residency covers a whole local period
  assign srcReady = srcTick & status.tailFree & (srcSafe | status.tailAged);
  assign dstValid = dstTick & status.headFull & (dstSafe | status.headAged);

  always_comb begin
    strobes         = '0;
    strobes.wrEn    = srcReady & srcValid;
    strobes.rdEn    = dstValid & dstReady;
    strobes.srcEdge = srcTick;
    strobes.dstEdge = dstTick;
  end

  // with unit divisors every master cycle must be a safe edge on both sides
  p_unity_all_safe_r8: assert property (@(posedge clk) disable iff (!rstN)
    (srcDiv == DIV_W'(1) && dstDiv == DIV_W'(1)) |-> (srcSafe && dstSafe));

  // a word is offered only when the storage reports one held
  p_valid_needs_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    dstValid |-> status.headFull);

  // the source is never accepted into an occupied slot
  p_ready_needs_room_r6: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> status.tailFree);

endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output storeStatus_t      status
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [DEPTH-1:0]  occVec;
  logic [DEPTH-1:0]  seenVec;
  logic [DEPTH-1:0]  freeVec;
  logic [DATA_W-1:0] slotData [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              occ;
    logic              seenAtDst;
    logic              freeAtSrc;
    logic [DATA_W-1:0] word;
    logic              wrHit;
    logic              rdHit;

    assign wrHit = strobes.wrEn & (wrPtr == PTR_W'(i));
    assign rdHit = strobes.rdEn & (rdPtr == PTR_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        occ       <= 1'b0;
        seenAtDst <= 1'b0;
        freeAtSrc <= 1'b1;
        word      <= '0;
      end else begin
        // record residency seen at each domain's edge
        if (strobes.dstEdge && occ) seenAtDst <= 1'b1;
        if (strobes.srcEdge && !occ) freeAtSrc <= 1'b1;
        if (rdHit) occ <= 1'b0;
        if (wrHit) begin
          occ       <= 1'b1;
          word      <= wrData;
          seenAtDst <= 1'b0;
          freeAtSrc <= 1'b0;
        end
      end
    end

    assign occVec[i]   = occ;
    assign seenVec[i]  = seenAtDst;
    assign freeVec[i]  = freeAtSrc;
    assign slotData[i] = word;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.wrEn) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + PTR_W'(1);
      if (strobes.rdEn) rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + PTR_W'(1);
    end
  end

  always_comb begin
    status          = '0;
    status.tailFree = ~occVec[wrPtr];
    status.tailAged = freeVec[wrPtr];
    status.headFull = occVec[rdPtr];
    status.headAged = seenVec[rdPtr];
  end

  assign rdData = slotData[rdPtr];

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |-> !occVec[wrPtr]);

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdEn |-> occVec[rdPtr]);

  p_read_advances_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdEn |=> (rdPtr != $past(rdPtr)));

  p_write_fills_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEn && !strobes.rdEn) |=> ($countones(occVec) == $past($countones(occVec)) + 1));

endmodule

// File: rtl/ratio_xing_queue.sv
module ratio_xing_queue
  import rxq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 4,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  srcDiv,
  input  logic [DIV_W-1:0]  dstDiv,
  input  logic              srcValid,
  output logic              srcReady,
  input  logic [DATA_W-1:0] srcData,
  output logic              dstValid,
  input  logic              dstReady,
  output logic [DATA_W-1:0] dstData
);

  logic         srcTick;
  logic         srcNext;
  logic         srcPrev;
  logic         dstTick;
  logic         dstNext;
  logic         dstPrev;
  xferStrobes_t strobes;
  storeStatus_t status;

  rxq_edge_gen #(.DIV_W(DIV_W)) u_srcEdge (
    .clk(clk), .rstN(rstN), .div(srcDiv),
    .tick(srcTick), .tickNext(srcNext), .tickPrev(srcPrev)
  );

  rxq_edge_gen #(.DIV_W(DIV_W)) u_dstEdge (
    .clk(clk), .rstN(rstN), .div(dstDiv),
    .tick(dstTick), .tickNext(dstNext), .tickPrev(dstPrev)
  );

  rxq_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcDiv(srcDiv), .dstDiv(dstDiv),
    .srcTick(srcTick), .srcNext(srcNext), .srcPrev(srcPrev),
    .dstTick(dstTick), .dstNext(dstNext), .dstPrev(dstPrev),
    .srcValid(srcValid), .dstReady(dstReady), .status(status),
    .srcReady(srcReady), .dstValid(dstValid), .strobes(strobes)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrData(srcData), .rdData(dstData), .status(status)
  );

endmodule

// File: tb/sim_ratio_xing_queue.sv
module sim_ratio_xing_queue;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  srcDiv = 4'd1;
  logic [3:0]  dstDiv = 4'd1;
  logic        srcValid = 1'b0;
  logic        srcReady;
  logic [31:0] srcData = '0;
  logic        dstValid;
  logic        dstReady = 1'b0;
  logic [31:0] dstData;

  always #2.5 clk = ~clk;  // 200 MHz master clock

  ratio_xing_queue u0 (
    .clk(clk), .rstN(rstN), .srcDiv(srcDiv), .dstDiv(dstDiv),
    .srcValid(srcValid), .srcReady(srcReady), .srcData(srcData),
    .dstValid(dstValid), .dstReady(dstReady), .dstData(dstData)
  );

  int checks = 0;
  int failures = 0;
  int n = 0;
  int pushes = 0;
  int pops = 0;
  int pushT [4096];
  int popT  [4096];
  int sd = 1;
  int dd = 1;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s cycle=%0d div=%0d/%0d actual=%0h expected=%0h",
               req, what, n, sd, dd, act, exp);
    end
  endtask

  function automatic logic [31:0] itemVal(input int k);
    return (k * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic bit isTick(input int c, input int d);
    return (c % d) == 0;
  endfunction

  // R3: safety from the other domain's neighbouring edges
  function automatic bit edgeSafe(input int c, input int d, input int other);
    bit near;
    if (!isTick(c, d)) return 1'b0;
    if (isTick(c, other)) return 1'b1;
    near = ((c >= 1) && isTick(c - 1, other)) || isTick(c + 1, other);
    return !near;
  endfunction

  function automatic int prevTick(input int c, input int d);
    if (c == 0) return -1;
    return (c - 1) - ((c - 1) % d);
  endfunction

  task automatic doCycle(input bit sv, input bit dr);
    bit    sTick, dTick, expRdy, expVld;
    int    pending;
    string rq;
    srcValid = sv;
    srcData  = itemVal(pushes);
    dstReady = dr;
    #1;
    sTick   = isTick(n, sd);
    dTick   = isTick(n, dd);
    pending = pushes - pops;
    expRdy  = sTick && pending < 2 &&
              (edgeSafe(n, sd, dd) || pushes < 2 || prevTick(n, sd) > popT[(pushes - 2) % 4096]);
    expVld  = dTick && pending > 0 &&
              (edgeSafe(n, dd, sd) || prevTick(n, dd) > pushT[pops % 4096]);
    if (n == 0) begin
      chk(dstValid == 1'b0, "R1", "empty after reset", {31'd0, dstValid}, 32'd0);
      chk(srcReady == 1'b1, "R1", "ready after reset", {31'd0, srcReady}, 32'd1);
    end
    if (sd == 1 && dd == 1) rq = "R8";
    else if (!sTick) rq = "R2";
    else if (pending == 2) rq = "R6";
    else if (!edgeSafe(n, sd, dd)) rq = "R3";
    else rq = "R5";
    chk(srcReady == expRdy, rq, "srcReady", {31'd0, srcReady}, {31'd0, expRdy});
    if (sd == 1 && dd == 1) rq = "R8";
    else if (!dTick) rq = "R2";
    else if (!edgeSafe(n, dd, sd)) rq = "R3";
    else rq = "R4";
    chk(dstValid == expVld, rq, "dstValid", {31'd0, dstValid}, {31'd0, expVld});
    if (srcValid && srcReady) begin
      pushT[pushes % 4096] = n;
      pushes++;
    end
    if (dstValid && dstReady) begin
      chk(dstData == itemVal(pops), "R7", "order", dstData, itemVal(pops));
      popT[pops % 4096] = n;
      pops++;
    end
    n++;
    @(negedge clk);
  endtask

  task automatic runPair(input int s, input int d, input int cyc);
    sd = s;
    dd = d;
    rstN = 1'b0;
    srcDiv = 4'(s);
    dstDiv = 4'(d);
    srcValid = 1'b0;
    dstReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    n = 0;
    pushes = 0;
    pops = 0;
    // random traffic
    for (int i = 0; i < cyc; i++)
      doCycle(($urandom % 100) < 70, ($urandom % 100) < 65);
    // directed stall: destination blocked until both slots fill (R6)
    for (int i = 0; i < 40; i++) doCycle(1'b1, 1'b0);
    chk(pushes - pops == 2, "R6", "fill level", 32'(pushes - pops), 32'd2);
    // drain
    for (int i = 0; i < 80; i++) doCycle(1'b0, 1'b1);
    chk(pushes == pops, "R7", "drained", 32'(pops), 32'(pushes));
    chk(pushes > 2, "R7", "traffic moved", 32'(pushes), 32'd3);
  endtask

  initial begin
    int divs [3];
    void'($urandom(32'd20240611));
    divs[0] = 2;
    divs[1] = 3;
    divs[2] = 9;
    @(negedge clk);
    // R7: every ordered pair of fast, middle and slow divisors
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        runPair(divs[a], divs[b], 500);
    // R8: unit divisors
    runPair(1, 1, 400);
    // R9: a wide divisor against the fastest
    runPair(15, 2, 400);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule